// File: doc/BRIEF.md
# Coalescing Host Interrupt Aggregator

This block gathers device event causes into a single host-visible summary status word and drives one interrupt line toward the host. Causes arrive from two sources. General device events set summary bits directly. Per-channel events from the DMA flow handler are held in a second status word, and groups of those bits are folded into a few summary bits. Every status bit stays set until the host writes a one to its position. A mask word selects which summary bits may raise the line.

To cut the host interrupt rate, the line does not rise as soon as an unmasked cause appears. The first such cause after the line has gone idle starts a coalescing timer that counts in units of 32 µs. The line rises when the timer runs out, so that later events are reported with the first one. A high-priority receive cause skips this wait. A separate periodic timer can set a receive-periodic summary bit at a programmable interval.

The host reaches all state through a small word-addressed register port. Reads are combinational and writes take effect at the clock edge.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the summary status, flow status and mask words read 0, the timing word (address 3) reads 0x0000_0040, and `irq` is low.
- R2: Writing a one to a bit of the summary status (address 0) or the flow status (address 2) clears that bit. Writing a zero leaves the bit unchanged.
- R3: A status bit that hardware sets in the same cycle as a host write-one-to-clear of that bit stays set.
- R4: Summary bit 31 (receive DMA) reads as the OR of flow bits 16, 17 and 30. Bits from `dev_ev` at positions 31, 29 and 27 are ignored.
- R5: Summary bit 27 (transmit DMA) reads as the OR of flow bits 0 and 1. Summary bit 29 (hardware error) reads as flow bit 31.
- R6: `irq` rises only when the AND of summary status and mask (address 1) is nonzero. A cause that is set but masked leaves `irq` low.
- R7: With coalescing timeout N (address 3, bits 7:0) nonzero, `irq` rises between N-1 and N+1 time units after the first unmasked cause. One time unit is UNIT_CYCLES clocks, which is 32 µs at the default.
- R8: With coalescing timeout 0, `irq` rises one clock after an unmasked cause becomes visible in the status.
- R9: If flow bit 30 (high-priority receive) is set and mask bit 31 is set, `irq` rises on the next clock, whatever the coalescing timeout is.
- R10: With periodic interval P (address 3, bits 15:8) nonzero, summary bit 28 is set every P time units. With P = 0 the bit is never set by the block.
- R11: `irq` falls on the clock after no unmasked summary bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 summary, 1 mask, 2 flow, 3 timing |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| dev_ev | input | 32 | One-cycle pulses that set summary status bits |
| flow_ev | input | 32 | One-cycle pulses that set flow status bits |
| irq | output | 1 | Host interrupt line |

## Verification
A hardware set and a host write-one-to-clear of the same bit can land in the same clock. The bench first sets a bit. It then drives the matching event pulse and a clearing write to that bit in one cycle, on both the summary and the flow word, and reads back to confirm the bit survived. A high-priority cause can also arrive while the coalescing timer is running. This is judged by whether the line rises on the next clock instead of waiting for the timer.

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int         UNIT_CYCLES = 1600,
  parameter logic [7:0] COAL_RESET  = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] dev_ev,
  input  logic [31:0] flow_ev,
  output logic        irq
);
  localparam int          PW       = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(UNIT_CYCLES - 1);
  localparam logic [31:0] FOLD     = 32'hA800_0000;
  localparam logic [31:0] PER_BIT  = 32'h1000_0000;

  logic [31:0]   st_q, fl_q, mask_q;
  logic [7:0]    coal_q, per_q, per_cnt_q, rem_q;
  logic [PW-1:0] pre_q;
  logic          armed_q, irq_q;

  logic [31:0] fold, sum, st_clr, fl_clr;
  logic        pend, hipri, unit_tick, per_hit, wr_tim;

  assign fold = {fl_q[17] | fl_q[16] | fl_q[30], 1'b0, fl_q[31], 1'b0,
                 fl_q[1] | fl_q[0], 27'b0};
  assign sum       = st_q | fold;
  assign pend      = |(sum & mask_q);
  assign hipri     = fl_q[30] & mask_q[31];
  assign unit_tick = (pre_q == PRE_LAST);
  assign per_hit   = unit_tick && (per_q != 8'd0) && (per_cnt_q == per_q - 8'd1);
  assign wr_tim    = reg_we && (reg_addr == 2'd3);
  assign st_clr    = (reg_we && reg_addr == 2'd0) ? reg_wdata : 32'b0;
  assign fl_clr    = (reg_we && reg_addr == 2'd2) ? reg_wdata : 32'b0;
  assign irq       = irq_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = sum;
      2'd1:    reg_rdata = mask_q;
      2'd2:    reg_rdata = fl_q;
      default: reg_rdata = {16'b0, per_q, coal_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      fl_q   <= '0;
      mask_q <= '0;
      coal_q <= COAL_RESET;
      per_q  <= '0;
    end else begin
      st_q <= (st_q & ~st_clr) | ((dev_ev | (per_hit ? PER_BIT : 32'b0)) & ~FOLD);
      fl_q <= (fl_q & ~fl_clr) | flow_ev;
      if (reg_we && reg_addr == 2'd1) mask_q <= reg_wdata;
      if (wr_tim) begin
        coal_q <= reg_wdata[7:0];
        per_q  <= reg_wdata[15:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q     <= '0;
      per_cnt_q <= '0;
    end else begin
      pre_q <= unit_tick ? '0 : pre_q + 1'b1;
      if (wr_tim || per_q == 8'd0)
        per_cnt_q <= '0;
      else if (unit_tick)
        per_cnt_q <= per_hit ? 8'd0 : per_cnt_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b0;
      rem_q   <= '0;
    end else if (!pend) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (irq_q) begin
      armed_q <= 1'b0;
    end else if (coal_q == 8'd0 || hipri) begin
      irq_q   <= 1'b1;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      rem_q   <= coal_q;
    end else if (rem_q == 8'd0) begin
      irq_q   <= 1'b1;
      armed_q <= 1'b0;
    end else if (unit_tick) begin
      rem_q <= rem_q - 8'd1;
    end
  end
endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        pend,
  input logic        hipri,
  input logic [7:0]  coal,
  input logic [31:0] flow_ev,
  input logic [31:0] fl_q
);
  a_r6_rise_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pend));

  a_r11_drop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !irq);

  a_r9_hipri_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    hipri |=> irq);

  a_r8_zero_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && coal == 8'd0) |=> irq);

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_ev != 32'b0) |=> ((fl_q & $past(flow_ev)) == $past(flow_ev)));
endmodule

bind irq_coalescer irq_coalescer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pend(pend), .hipri(hipri),
  .coal(coal_q), .flow_ev(flow_ev), .fl_q(fl_q)
);

// File: tb/test_irq_coalescer.sv
module test_irq_coalescer;
  localparam int U = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] dev_ev = '0;
  logic [31:0] flow_ev = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  irq_coalescer #(.UNIT_CYCLES(U)) i_irq_coalescer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_ev(dev_ev),
    .flow_ev(flow_ev), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ev(input logic [31:0] dv, input logic [31:0] fv);
    @(negedge clk);
    dev_ev = dv; flow_ev = fv;
    @(negedge clk);
    dev_ev = '0; flow_ev = '0;
  endtask

  task automatic clean();
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    cyc(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 status", d, 32'h0);
    rd(2'd1, d); check("R1 mask", d, 32'h0);
    rd(2'd2, d); check("R1 flow", d, 32'h0);
    rd(2'd3, d); check("R1 timing", d, 32'h0000_0040);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    clean();
    ev(32'h0000_0009, 32'h0000_0003);
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, d); check("R2 clear one bit", d & 32'h0000_00FF, 32'h0000_0008);
    wr(2'd0, 32'h0);
    rd(2'd0, d); check("R2 zero write no effect", d & 32'h0000_00FF, 32'h0000_0008);
    wr(2'd2, 32'h0000_0002);
    rd(2'd2, d); check("R2 flow clear", d, 32'h0000_0001);
  endtask

  task automatic t_race();
    logic [31:0] d;
    clean();
    ev(32'h0000_0020, 32'h0000_0400);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0020; dev_ev = 32'h0000_0020;
    @(negedge clk);
    reg_we = 1'b0; dev_ev = '0;
    rd(2'd0, d); check("R3 summary set beats clear", d & 32'h0000_0020, 32'h0000_0020);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0000_0400; flow_ev = 32'h0000_0400;
    @(negedge clk);
    reg_we = 1'b0; flow_ev = '0;
    rd(2'd2, d); check("R3 flow set beats clear", d, 32'h0000_0400);
  endtask

  task automatic t_fold();
    logic [31:0] d;
    clean();
    ev(32'hA800_0000, 32'h0);
    rd(2'd0, d); check("R4 dev bits at fold positions ignored", d, 32'h0);
    ev(32'h0, 32'h0002_0000);
    rd(2'd0, d); check("R4 rx channel 1 folds to bit 31", d, 32'h8000_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    ev(32'h0, 32'h0001_0000);
    rd(2'd0, d); check("R4 rx channel 0 folds to bit 31", d, 32'h8000_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    ev(32'h0, 32'h0000_0001);
    rd(2'd0, d); check("R5 tx channel 0 folds to bit 27", d, 32'h0800_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    ev(32'h0, 32'h0000_0002);
    rd(2'd0, d); check("R5 tx channel 1 folds to bit 27", d, 32'h0800_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    ev(32'h0, 32'h8000_0000);
    rd(2'd0, d); check("R5 error folds to bit 29", d, 32'h2000_0000);
  endtask

  task automatic t_mask();
    clean();
    ev(32'h0000_0008, 32'h0);
    cyc(3);
    check("R6 masked cause keeps irq low", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h0000_0008);
    cyc(1);
    check("R6 unmasked cause raises irq", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0008);
    cyc(1);
    check("R11 irq drops after ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_coal();
    clean();
    wr(2'd3, 32'h0000_0003);
    wr(2'd1, 32'h0000_0001);
    ev(32'h0000_0001, 32'h0);
    cyc(8);
    check("R7 irq held during coalescing", {31'b0, irq}, 32'h0);
    cyc(8);
    check("R7 irq after timeout", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0001);
    cyc(1);
    check("R11 irq drops after coalesced ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_zero();
    clean();
    wr(2'd1, 32'h0000_0002);
    @(negedge clk);
    dev_ev = 32'h0000_0002;
    @(negedge clk);
    dev_ev = '0;
    check("R8 not yet high when status just set", {31'b0, irq}, 32'h0);
    cyc(1);
    check("R8 zero timeout raises next clock", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_hipri();
    logic [31:0] d;
    clean();
    wr(2'd3, 32'h0000_00FF);
    wr(2'd1, 32'h8000_0000);
    ev(32'h0, 32'h4000_0000);
    rd(2'd0, d); check("R4 high-priority folds to bit 31", d, 32'h8000_0000);
    cyc(1);
    check("R9 high-priority bypasses coalescing", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h4000_0000);
    cyc(1);
    check("R11 irq drops after flow ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    clean();
    wr(2'd3, 32'h0000_0200);
    cyc(2 * U + 2);
    rd(2'd0, d); check("R10 periodic bit set", d & 32'h1000_0000, 32'h1000_0000);
    wr(2'd0, 32'h1000_0000);
    cyc(2 * U + 2);
    rd(2'd0, d); check("R10 periodic bit set again", d & 32'h1000_0000, 32'h1000_0000);
    wr(2'd3, 32'h0000_0000);
    wr(2'd0, 32'h1000_0000);
    cyc(10 * U);
    rd(2'd0, d); check("R10 interval 0 never sets", d & 32'h1000_0000, 32'h0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_w1c();
    t_race();
    t_fold();
    t_mask();
    t_coal();
    t_zero();
    t_hipri();
    t_periodic();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule